// File: doc/BRIEF.md
# Vector Lane Rotation Unit

This unit sits on the multiply side of a dual-issue vector ALU. The add path and the multiply path issue together in one instruction. Each instruction hands the unit one operand source select and one rotation amount. The amount comes either from a small immediate field or from the low bits of a register value. The unit returns the operand with its 16 lanes rotated, one cycle later.

Rotation is legal only when the source is an accumulator. The accumulator file, bank A and bank B are presented to the unit as input vectors. The unit does not store them.

The unit keeps a one-instruction record of which accumulators the previous instruction wrote, through either its add or its multiply path. If the instruction asks to rotate an accumulator that was written in the cycle just before, the request is a hazard. If it asks to rotate a bank register or an invalid index, the request is illegal. In both cases the operand comes out unrotated and a flag is raised.

Top module: `vrot_top`

## Requirements
- R1: For a legal, hazard-free rotation by n (0 to 15), output lane (i + n) mod 16 equals source lane i. The result appears with `outValid` high in the cycle after the instruction is presented.
- R2: When `amtFromReg` is 0 the amount is `amtImm`; when it is 1 the amount is `amtReg`, and `amtImm` has no effect.
- R3: `srcKind` encodes 0 = accumulator `accIdx`, 1 = bank A, 2 = bank B, 3 = none (all-zero operand). With `rotEn` low, the output is the selected source unchanged and no flag is raised.
- R4: With `rotEn` high, a `srcKind` other than 0, or an `accIdx` of 6 or more, raises `errIllegal`. The output is then the unrotated selected source, which is zero for an invalid index.
- R5: With `rotEn` high and a legal accumulator source, if the immediately preceding cycle held a valid instruction that wrote that accumulator through its add or its multiply path, `errHazard` is raised and the output is the unrotated source.
- R6: The write history covers exactly one cycle. A write two instructions back, a write separated from the rotation by an idle cycle, a write to another accumulator, a write by the same instruction, and a non-rotating read of a just-written accumulator raise no flag.
- R7: `errIllegal` and `errHazard` are never high together.
- R8: A cycle with `instValid` low gives `outValid`, `errIllegal` and `errHazard` low in the next cycle, and leaves no write history.
- R9: During reset `outValid` and both flags are low. The write history is empty, so the first instruction after reset raises no hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | An instruction is presented this cycle |
| rotEn | input | 1 | The multiply-path operand is to be rotated |
| srcKind | input | 2 | Operand source kind (see R3) |
| accIdx | input | 3 | Accumulator index when srcKind is 0 |
| amtFromReg | input | 1 | Take the amount from amtReg instead of amtImm |
| amtImm | input | 4 | Immediate rotation amount |
| amtReg | input | 4 | Register-supplied rotation amount |
| accFile | input | 3072 | All six accumulators, accumulator k at bits k*512 upward |
| bankAVal | input | 512 | Operand read from bank A |
| bankBVal | input | 512 | Operand read from bank B |
| addWrEn | input | 1 | Add path of this instruction writes an accumulator |
| addWrAcc | input | 3 | Accumulator written by the add path |
| mulWrEn | input | 1 | Multiply path of this instruction writes an accumulator |
| mulWrAcc | input | 3 | Accumulator written by the multiply path |
| outValid | output | 1 | Result of the previous cycle's instruction is valid |
| outVec | output | 512 | Rotated (or passed-through) operand, lane i at bits i*32 upward |
| errIllegal | output | 1 | Rotation requested from an illegal source |
| errHazard | output | 1 | Rotation source was written by the previous instruction |

## Verification
Every lane holds a value that encodes its accumulator or bank and its lane number. A misrouted lane is therefore visible, and all 16 amounts are compared against a reference rotation. Runs with the amount taken from the immediate and then from the register, each with the other field set differently, show which field was used. Hazard sequences vary the writing path, the written index, the distance between write and rotation, and an intervening idle cycle. These separate a true one-cycle history from one that is too long, too short, or matched against the wrong index. Bank, reserved and out-of-range sources, with and without rotation, separate the illegal check from the plain operand path.

// File: rtl/vrot_pkg.sv
package vrot_pkg;

  typedef enum logic [1:0] {
    SRC_ACC   = 2'd0,
    SRC_BANKA = 2'd1,
    SRC_BANKB = 2'd2,
    SRC_NONE  = 2'd3
  } srcKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic doRotate;
    logic errIllegal;
    logic errHazard;
  } rotCtrlT;

endpackage

// File: rtl/vrot_ctrl.sv
module vrot_ctrl
  import vrot_pkg::*;
#(
  parameter int ACC_NUM   = 6,
  parameter int ACC_IDX_W = $clog2(ACC_NUM)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic                 rotEn,
  input  logic [1:0]           srcKind,
  input  logic [ACC_IDX_W-1:0] accIdx,
  input  logic                 addWrEn,
  input  logic [ACC_IDX_W-1:0] addWrAcc,
  input  logic                 mulWrEn,
  input  logic [ACC_IDX_W-1:0] mulWrAcc,
  output rotCtrlT              ctrl
);

  logic [ACC_NUM-1:0] histQ;
  logic [ACC_NUM-1:0] wrMask;
  logic               legalSrc;
  logic               histHit;

  always_comb begin
    wrMask  = '0;
    histHit = 1'b0;
    for (int k = 0; k < ACC_NUM; k++) begin
      wrMask[k] = (addWrEn && addWrAcc == ACC_IDX_W'(k)) ||
                  (mulWrEn && mulWrAcc == ACC_IDX_W'(k));
      if (accIdx == ACC_IDX_W'(k) && histQ[k]) histHit = 1'b1;
    end
  end

  assign legalSrc = (srcKindT'(srcKind) == SRC_ACC) && (int'(accIdx) < ACC_NUM);

  always_comb begin
    ctrl.errIllegal = rotEn && !legalSrc;
    ctrl.errHazard  = rotEn && legalSrc && histHit;
    ctrl.doRotate   = rotEn && legalSrc && !histHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          histQ <= '0;
    else if (instValid) histQ <= wrMask;
    else                histQ <= '0;
  end

  // R5: a rotation of an accumulator written one cycle earlier is flagged
  p_hazard_flagged_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && rotEn && srcKind == 2'd0 && int'(accIdx) < ACC_NUM &&
     $past(instValid) &&
     (($past(addWrEn) && $past(addWrAcc) == accIdx) ||
      ($past(mulWrEn) && $past(mulWrAcc) == accIdx)))
    |-> ctrl.errHazard);

  // R6: an idle cycle leaves no history behind
  p_idle_no_hazard_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(instValid)) |-> !ctrl.errHazard);

endmodule

// File: rtl/vrot_dp.sv
module vrot_dp
  import vrot_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int LANE_W    = 32,
  parameter int ACC_NUM   = 6,
  parameter int AMT_W     = $clog2(LANES),
  parameter int ACC_IDX_W = $clog2(ACC_NUM),
  parameter int VEC_W     = LANES * LANE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     instValid,
  input  rotCtrlT                  ctrl,
  input  logic [1:0]               srcKind,
  input  logic [ACC_IDX_W-1:0]     accIdx,
  input  logic                     amtFromReg,
  input  logic [AMT_W-1:0]         amtImm,
  input  logic [AMT_W-1:0]         amtReg,
  input  logic [ACC_NUM*VEC_W-1:0] accFile,
  input  logic [VEC_W-1:0]         bankAVal,
  input  logic [VEC_W-1:0]         bankBVal,
  output logic                     outValid,
  output logic [VEC_W-1:0]         outVec,
  output logic                     errIllegal,
  output logic                     errHazard
);

  logic [VEC_W-1:0] srcVec;
  logic [VEC_W-1:0] rotVec;
  logic [AMT_W-1:0] amtSel;

  always_comb begin
    srcVec = '0;
    case (srcKindT'(srcKind))
      SRC_ACC: begin
        for (int k = 0; k < ACC_NUM; k++)
          if (accIdx == ACC_IDX_W'(k)) srcVec = accFile[k*VEC_W +: VEC_W];
      end
      SRC_BANKA: srcVec = bankAVal;
      SRC_BANKB: srcVec = bankBVal;
      default:   srcVec = '0;
    endcase
  end

  assign amtSel = amtFromReg ? amtReg : amtImm;

  // lane j takes lane (j - n) mod LANES; LANES is a power of two
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [AMT_W-1:0] fromLane;
    assign fromLane = AMT_W'(j) - amtSel;
    assign rotVec[j*LANE_W +: LANE_W] = srcVec[fromLane*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outVec     <= '0;
      errIllegal <= 1'b0;
      errHazard  <= 1'b0;
    end else begin
      outValid   <= instValid;
      errIllegal <= instValid && ctrl.errIllegal;
      errHazard  <= instValid && ctrl.errHazard;
      if (instValid) outVec <= ctrl.doRotate ? rotVec : srcVec;
    end
  end

  // R1: source lane 0 lands in lane n
  p_lane0_moves_r1: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && ctrl.doRotate) |=>
    outVec[$past(amtSel)*LANE_W +: LANE_W] == $past(srcVec[LANE_W-1:0]));

  // R4: without a rotation the operand passes unchanged
  p_unrotated_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !ctrl.doRotate) |=> outVec == $past(srcVec));

  // R7: at most one error flag
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errIllegal, errHazard}));

  // R8: an idle cycle produces no valid result
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> (!outValid && !errIllegal && !errHazard));

endmodule

// File: rtl/vrot_top.sv
module vrot_top
  import vrot_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int LANE_W    = 32,
  parameter int ACC_NUM   = 6,
  localparam int AMT_W     = $clog2(LANES),
  localparam int ACC_IDX_W = $clog2(ACC_NUM),
  localparam int VEC_W     = LANES * LANE_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     instValid,
  input  logic                     rotEn,
  input  logic [1:0]               srcKind,
  input  logic [ACC_IDX_W-1:0]     accIdx,
  input  logic                     amtFromReg,
  input  logic [AMT_W-1:0]         amtImm,
  input  logic [AMT_W-1:0]         amtReg,
  input  logic [ACC_NUM*VEC_W-1:0] accFile,
  input  logic [VEC_W-1:0]         bankAVal,
  input  logic [VEC_W-1:0]         bankBVal,
  input  logic                     addWrEn,
  input  logic [ACC_IDX_W-1:0]     addWrAcc,
  input  logic                     mulWrEn,
  input  logic [ACC_IDX_W-1:0]     mulWrAcc,
  output logic                     outValid,
  output logic [VEC_W-1:0]         outVec,
  output logic                     errIllegal,
  output logic                     errHazard
);

  rotCtrlT ctrl;

  vrot_ctrl #(.ACC_NUM(ACC_NUM), .ACC_IDX_W(ACC_IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .rotEn(rotEn),
    .srcKind(srcKind), .accIdx(accIdx),
    .addWrEn(addWrEn), .addWrAcc(addWrAcc),
    .mulWrEn(mulWrEn), .mulWrAcc(mulWrAcc),
    .ctrl(ctrl)
  );

  vrot_dp #(.LANES(LANES), .LANE_W(LANE_W), .ACC_NUM(ACC_NUM),
            .AMT_W(AMT_W), .ACC_IDX_W(ACC_IDX_W), .VEC_W(VEC_W)) dp_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .ctrl(ctrl),
    .srcKind(srcKind), .accIdx(accIdx),
    .amtFromReg(amtFromReg), .amtImm(amtImm), .amtReg(amtReg),
    .accFile(accFile), .bankAVal(bankAVal), .bankBVal(bankBVal),
    .outValid(outValid), .outVec(outVec),
    .errIllegal(errIllegal), .errHazard(errHazard)
  );

endmodule

// File: tb/vrot_top_tb.sv
module vrot_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 16;
  localparam int LANE_W = 32;
  localparam int ACC_N  = 6;
  localparam int VEC_W  = LANES * LANE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 0, rotEn = 0, amtFromReg = 0;
  logic [1:0] srcKind = 0;
  logic [2:0] accIdx = 0, addWrAcc = 0, mulWrAcc = 0;
  logic [3:0] amtImm = 0, amtReg = 0;
  logic addWrEn = 0, mulWrEn = 0;
  logic [ACC_N*VEC_W-1:0] accFile;
  logic [VEC_W-1:0] bankAVal, bankBVal;
  logic outValid, errIllegal, errHazard;
  logic [VEC_W-1:0] outVec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrot_top dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .rotEn(rotEn),
    .srcKind(srcKind), .accIdx(accIdx), .amtFromReg(amtFromReg),
    .amtImm(amtImm), .amtReg(amtReg), .accFile(accFile),
    .bankAVal(bankAVal), .bankBVal(bankBVal),
    .addWrEn(addWrEn), .addWrAcc(addWrAcc),
    .mulWrEn(mulWrEn), .mulWrAcc(mulWrAcc),
    .outValid(outValid), .outVec(outVec),
    .errIllegal(errIllegal), .errHazard(errHazard)
  );

  function automatic logic [VEC_W-1:0] srcRef(input int kind, input int idx);
    if (kind == 0 && idx < ACC_N) return accFile[idx*VEC_W +: VEC_W];
    if (kind == 1) return bankAVal;
    if (kind == 2) return bankBVal;
    return '0;
  endfunction

  function automatic logic [VEC_W-1:0] rotRef(input logic [VEC_W-1:0] v, input int n);
    logic [VEC_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[((i + n) % LANES)*LANE_W +: LANE_W] = v[i*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic check(input string req, input logic [VEC_W-1:0] expVec,
                       input logic expIll, input logic expHaz);
    checks++;
    if (outValid !== 1'b1 || outVec !== expVec ||
        errIllegal !== expIll || errHazard !== expHaz) begin
      errors++;
      $display("FAIL %s: valid=%b ill=%b haz=%b vec=%h expected valid=1 ill=%b haz=%b vec=%h",
               req, outValid, errIllegal, errHazard, outVec, expIll, expHaz, expVec);
    end
  endtask

  task automatic issue(input bit rot, input int kind, input int idx,
                       input bit fromReg, input int imm, input int regv,
                       input bit awe, input int awa, input bit mwe, input int mwa);
    @(negedge clk);
    instValid = 1; rotEn = rot; srcKind = 2'(kind); accIdx = 3'(idx);
    amtFromReg = fromReg; amtImm = 4'(imm); amtReg = 4'(regv);
    addWrEn = awe; addWrAcc = 3'(awa); mulWrEn = mwe; mulWrAcc = 3'(mwa);
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 0; rotEn = 0; addWrEn = 0; mulWrEn = 0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    checks++;
    if (outValid !== 0 || errIllegal !== 0 || errHazard !== 0) begin
      errors++;
      $display("FAIL R9: in reset valid=%b ill=%b haz=%b expected 0 0 0",
               outValid, errIllegal, errHazard);
    end
    @(negedge clk); rstN = 1;
    issue(1, 0, 0, 0, 3, 0, 0, 0, 0, 0);
    check("R9", rotRef(srcRef(0, 0), 3), 0, 0);
  endtask

  task automatic t_all_imm();
    for (int n = 0; n < LANES; n++) begin
      issue(1, 0, n % ACC_N, 0, n, 15 - n, 0, 0, 0, 0);
      check("R1", rotRef(srcRef(0, n % ACC_N), n), 0, 0);
    end
  endtask

  task automatic t_reg_amt();
    for (int n = 0; n < LANES; n += 3) begin
      issue(1, 0, 4, 1, (n + 5) % LANES, n, 0, 0, 0, 0);
      check("R2", rotRef(srcRef(0, 4), n), 0, 0);
    end
    issue(1, 0, 5, 0, 7, 2, 0, 0, 0, 0);
    check("R2", rotRef(srcRef(0, 5), 7), 0, 0);
  endtask

  task automatic t_no_rotate();
    for (int k = 0; k < 4; k++) begin
      issue(0, k, 2, 0, 9, 0, 0, 0, 0, 0);
      check("R3", srcRef(k, 2), 0, 0);
    end
  endtask

  task automatic t_illegal();
    for (int k = 1; k < 4; k++) begin
      issue(1, k, 0, 0, 6, 0, 0, 0, 0, 0);
      check("R4", srcRef(k, 0), 1, 0);
    end
    issue(1, 0, 6, 0, 4, 0, 0, 0, 0, 0);
    check("R4", '0, 1, 0);
    issue(1, 0, 7, 1, 0, 8, 0, 0, 0, 0);
    check("R4", '0, 1, 0);
  endtask

  task automatic t_hazard();
    issue(0, 1, 0, 0, 0, 0, 1, 2, 0, 0);
    issue(1, 0, 2, 0, 5, 0, 0, 0, 0, 0);
    check("R5", srcRef(0, 2), 0, 1);
    issue(0, 2, 0, 0, 0, 0, 0, 0, 1, 5);
    issue(1, 0, 5, 1, 0, 11, 0, 0, 0, 0);
    check("R5", srcRef(0, 5), 0, 1);
    issue(0, 0, 0, 0, 0, 0, 1, 1, 1, 4);
    issue(1, 0, 4, 0, 2, 0, 0, 0, 0, 0);
    check("R5", srcRef(0, 4), 0, 1);
  endtask

  task automatic t_history();
    issue(0, 1, 0, 0, 0, 0, 1, 1, 0, 0);
    issue(1, 0, 2, 0, 3, 0, 0, 0, 0, 0);
    check("R6", rotRef(srcRef(0, 2), 3), 0, 0);
    issue(0, 1, 0, 0, 0, 0, 1, 1, 0, 0);
    issue(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    issue(1, 0, 1, 0, 6, 0, 0, 0, 0, 0);
    check("R6", rotRef(srcRef(0, 1), 6), 0, 0);
    issue(0, 1, 0, 0, 0, 0, 0, 0, 1, 3);
    idle();
    issue(1, 0, 3, 0, 1, 0, 0, 0, 0, 0);
    check("R6", rotRef(srcRef(0, 3), 1), 0, 0);
    issue(1, 0, 0, 0, 2, 0, 1, 0, 1, 0);
    check("R6", rotRef(srcRef(0, 0), 2), 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R6", srcRef(0, 0), 0, 0);
  endtask

  task automatic t_idle();
    idle();
    checks++;
    if (outValid !== 0 || errIllegal !== 0 || errHazard !== 0) begin
      errors++;
      $display("FAIL R8: idle valid=%b ill=%b haz=%b expected 0 0 0",
               outValid, errIllegal, errHazard);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < ACC_N; k++)
      for (int i = 0; i < LANES; i++)
        accFile[(k*LANES + i)*LANE_W +: LANE_W] = 32'hA000_0000 | (k << 8) | i;
    for (int i = 0; i < LANES; i++) begin
      bankAVal[i*LANE_W +: LANE_W] = 32'hB000_0000 | i;
      bankBVal[i*LANE_W +: LANE_W] = 32'hC000_0000 | i;
    end
    t_reset();
    t_all_imm();
    t_reg_amt();
    t_no_rotate();
    t_illegal();
    t_hazard();
    t_history();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

endmodule